// File: doc/BRIEF.md
# Eight-Point Integer Inverse DCT Row Unit

This block turns one row of eight signed 16-bit frequency coefficients into eight signed 16-bit spatial samples. It evaluates a butterfly factorisation of the one-dimensional inverse cosine transform. Every multiplication uses a cosine constant scaled by 2^14. Each pair of products is summed at full width, rounded once and cut back to 16 bits. All plain additions and subtractions between stages are 16-bit and wrap on overflow, so the result is bit-exact against an integer model of the same sequence.

A row is offered with a valid strobe and comes back on the output lanes one clock later, with its own valid strobe. A new row may be accepted on every clock and there is no stall path. When no row is offered, the output register keeps its last contents. A parameter can remove the output register, which makes the path purely combinational. Sequencing two passes into a 2-D transform is left to the surrounding logic, as is adding the result to a prediction.

Top module: `idct8_row`

## Requirements
- R1: Lane k (k = 0..7) of both the input and the output vector occupies bits [16k+15:16k]. Lane 0 of the input is the DC coefficient.
- R2: Every rotation result is computed as follows: form the signed sum of two 16x16 products at 32 bits, add 8192, shift right arithmetically by 14, and keep the low 16 bits. The constants are c4=16069, c8=15137, c12=13623, c16=11585, c20=9102, c24=6270 and c28=3196.
- R3: The even half forms e0 = rnd(x0*c16 + x4*c16), e1 = rnd(x0*c16 - x4*c16), e2 = rnd(x2*c24 - x6*c8) and e3 = rnd(x2*c8 + x6*c24). From these it forms d0 = e0+e3, d1 = e1+e2, d2 = e1-e2 and d3 = e0-e3.
- R4: The odd rotations are s4 = rnd(x1*c28 - x7*c4), s7 = rnd(x1*c4 + x7*c28), s5 = rnd(x5*c12 - x3*c20) and s6 = rnd(x5*c20 + x3*c12).
- R5: The odd half forms d4 = s4+s5 and d7 = s7+s6. With t0 = s4-s5 and t1 = s7-s6, it forms d5 = rnd(t1*c16 - t0*c16) and d6 = rnd(t1*c16 + t0*c16).
- R6: The outputs are y[k] = d[k] + d[7-k] and y[7-k] = d[k] - d[7-k] for k = 0..3. Every 16-bit add and subtract in R3, R5 and R6 wraps modulo 2^16.
- R7: out_vld equals in_vld delayed by exactly one clock. Rows offered on consecutive clocks produce results on consecutive clocks.
- R8: In a cycle where in_vld is low, out_samp keeps its previous value and the following out_vld is low, whatever in_coef holds.
- R9: While rst_n is low, out_vld is 0 and out_samp is all zeros.
- R10: A row with only lane 0 non-zero yields eight equal samples, each rnd(x0*c16).
- R11: A row whose odd lanes are all zero yields samples with mirror symmetry: y[k] = y[7-k].
- R12: A row whose even lanes are all zero yields anti-symmetric samples: y[k] = -y[7-k].
- R13: For coefficients with magnitude at most 512, each sample lies within 3 of the real-valued transform x0*cos(pi/4) + sum over k=1..7 of x[k]*cos((2n+1)k*pi/16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A coefficient row is present this cycle |
| in_coef | input | 128 | Eight signed 16-bit coefficients, lane k at bits [16k+15:16k] |
| out_vld | output | 1 | A sample row is present on out_samp |
| out_samp | output | 128 | Eight signed 16-bit samples, lane k at bits [16k+15:16k] |

## Verification
The bench drives a unit impulse into every lane at amplitudes up to full scale, including -32768. A swapped constant or a wrong sign in one rotation shows up there as a wrong row or a wrong lane. A DC sweep across 4096 values exercises the rounding offset. An off-by-one offset, or truncation where rounding is due, shifts roughly half the sweep by one. Full-range random rows drive the intermediate sums into wrap-around, which catches a design that saturates or widens them. Even-only and odd-only rows, a real-valued reference, idle cycles with changing input, and rows offered back to back each catch a different fault: a broken symmetry, accumulated rounding drift, an output that leaks while idle, and a latency off by a cycle.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

   // Number of lanes in one transform row.
   localparam int LANES = 8;

   // Default fraction bits of the cosine constants.
   localparam int Q_FRAC = 14;

   // Default cosine constants, round(2^14 * cos(k*pi/32)) for the listed k/2.
   localparam logic signed [15:0] K_C4  = 16'sd16069;
   localparam logic signed [15:0] K_C8  = 16'sd15137;
   localparam logic signed [15:0] K_C12 = 16'sd13623;
   localparam logic signed [15:0] K_C16 = 16'sd11585;
   localparam logic signed [15:0] K_C20 = 16'sd9102;
   localparam logic signed [15:0] K_C24 = 16'sd6270;
   localparam logic signed [15:0] K_C28 = 16'sd3196;

endpackage

// File: rtl/idct8_rot.sv
// Rotation pair: p = rnd(a*ka - b*kb), q = rnd(a*kb + b*ka).
// Each product sum is formed wide, rounded once and narrowed to DW bits.
module idct8_rot #(
   parameter int DW   = 16,
   parameter int KW   = 16,
   parameter int FRAC = 14
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   input  logic signed [KW-1:0] ka,
   input  logic signed [KW-1:0] kb,
   output logic signed [DW-1:0] p,
   output logic signed [DW-1:0] q
);

   localparam int AW = DW + KW;   // product width
   localparam int SW = AW + 1;    // sum width, one guard bit
   localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);

   generate
      if (FRAC < 1 || FRAC >= KW) begin : g_bad_frac
         $error("idct8_rot: FRAC must lie in 1..KW-1");
      end
      if (DW < 4) begin : g_bad_dw
         $error("idct8_rot: DW too small");
      end
   endgenerate

   logic signed [AW-1:0] m_a_ka;
   logic signed [AW-1:0] m_b_kb;
   logic signed [AW-1:0] m_a_kb;
   logic signed [AW-1:0] m_b_ka;
   logic signed [SW-1:0] sum_p;
   logic signed [SW-1:0] sum_q;
   logic signed [SW-1:0] rnd_p;
   logic signed [SW-1:0] rnd_q;

   assign m_a_ka = AW'(a) * AW'(ka);
   assign m_b_kb = AW'(b) * AW'(kb);
   assign m_a_kb = AW'(a) * AW'(kb);
   assign m_b_ka = AW'(b) * AW'(ka);

   assign sum_p = SW'(m_a_ka) - SW'(m_b_kb);
   assign sum_q = SW'(m_a_kb) + SW'(m_b_ka);

   assign rnd_p = sum_p + HALF;
   assign rnd_q = sum_q + HALF;

   assign p = DW'(rnd_p >>> FRAC);
   assign q = DW'(rnd_q >>> FRAC);

endmodule

// File: rtl/idct8_even.sv
// Even half: coefficients 0, 2, 4, 6 into d0..d3.
module idct8_even #(
   parameter int DW   = 16,
   parameter int KW   = 16,
   parameter int FRAC = 14,
   parameter logic signed [KW-1:0] C8  = 15137,
   parameter logic signed [KW-1:0] C16 = 11585,
   parameter logic signed [KW-1:0] C24 = 6270
) (
   input  logic signed [DW-1:0] x0,
   input  logic signed [DW-1:0] x2,
   input  logic signed [DW-1:0] x4,
   input  logic signed [DW-1:0] x6,
   output logic signed [DW-1:0] d0,
   output logic signed [DW-1:0] d1,
   output logic signed [DW-1:0] d2,
   output logic signed [DW-1:0] d3
);

   logic signed [DW-1:0] e0;
   logic signed [DW-1:0] e1;
   logic signed [DW-1:0] e2;
   logic signed [DW-1:0] e3;

   // DC pair: e1 = rnd(x0*c16 - x4*c16), e0 = rnd(x0*c16 + x4*c16)
   idct8_rot #(.DW(DW), .KW(KW), .FRAC(FRAC)) u_rot_dc (
      .a  (x0),
      .b  (x4),
      .ka (C16),
      .kb (C16),
      .p  (e1),
      .q  (e0)
   );

   // Second pair: e2 = rnd(x2*c24 - x6*c8), e3 = rnd(x2*c8 + x6*c24)
   idct8_rot #(.DW(DW), .KW(KW), .FRAC(FRAC)) u_rot_26 (
      .a  (x2),
      .b  (x6),
      .ka (C24),
      .kb (C8),
      .p  (e2),
      .q  (e3)
   );

   // 16-bit wrapping butterfly
   assign d0 = e0 + e3;
   assign d1 = e1 + e2;
   assign d2 = e1 - e2;
   assign d3 = e0 - e3;

endmodule

// File: rtl/idct8_odd.sv
// Odd half: coefficients 1, 3, 5, 7 into d4..d7.
module idct8_odd #(
   parameter int DW   = 16,
   parameter int KW   = 16,
   parameter int FRAC = 14,
   parameter logic signed [KW-1:0] C4  = 16069,
   parameter logic signed [KW-1:0] C12 = 13623,
   parameter logic signed [KW-1:0] C16 = 11585,
   parameter logic signed [KW-1:0] C20 = 9102,
   parameter logic signed [KW-1:0] C28 = 3196
) (
   input  logic signed [DW-1:0] x1,
   input  logic signed [DW-1:0] x3,
   input  logic signed [DW-1:0] x5,
   input  logic signed [DW-1:0] x7,
   output logic signed [DW-1:0] d4,
   output logic signed [DW-1:0] d5,
   output logic signed [DW-1:0] d6,
   output logic signed [DW-1:0] d7
);

   logic signed [DW-1:0] s4;
   logic signed [DW-1:0] s5;
   logic signed [DW-1:0] s6;
   logic signed [DW-1:0] s7;
   logic signed [DW-1:0] t0;
   logic signed [DW-1:0] t1;

   // Outer pair: s4 = rnd(x1*c28 - x7*c4), s7 = rnd(x1*c4 + x7*c28)
   idct8_rot #(.DW(DW), .KW(KW), .FRAC(FRAC)) u_rot_17 (
      .a  (x1),
      .b  (x7),
      .ka (C28),
      .kb (C4),
      .p  (s4),
      .q  (s7)
   );

   // Inner pair: s5 = rnd(x5*c12 - x3*c20), s6 = rnd(x5*c20 + x3*c12)
   idct8_rot #(.DW(DW), .KW(KW), .FRAC(FRAC)) u_rot_53 (
      .a  (x5),
      .b  (x3),
      .ka (C12),
      .kb (C20),
      .p  (s5),
      .q  (s6)
   );

   // Stage two: wrapping sums and differences
   assign d4 = s4 + s5;
   assign d7 = s7 + s6;
   assign t0 = s4 - s5;
   assign t1 = s7 - s6;

   // Stage three: rotate the differences by cos(pi/4)
   idct8_rot #(.DW(DW), .KW(KW), .FRAC(FRAC)) u_rot_mid (
      .a  (t1),
      .b  (t0),
      .ka (C16),
      .kb (C16),
      .p  (d5),
      .q  (d6)
   );

endmodule

// File: rtl/idct8_row.sv
// One-dimensional eight-point inverse DCT with optional output register.
module idct8_row
   import idct8_pkg::*;
#(
   parameter int DW      = 16,
   parameter int KW      = 16,
   parameter int FRAC    = Q_FRAC,
   parameter int REG_OUT = 1,
   parameter logic signed [KW-1:0] C4  = KW'(K_C4),
   parameter logic signed [KW-1:0] C8  = KW'(K_C8),
   parameter logic signed [KW-1:0] C12 = KW'(K_C12),
   parameter logic signed [KW-1:0] C16 = KW'(K_C16),
   parameter logic signed [KW-1:0] C20 = KW'(K_C20),
   parameter logic signed [KW-1:0] C24 = KW'(K_C24),
   parameter logic signed [KW-1:0] C28 = KW'(K_C28)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [LANES*DW-1:0]   in_coef,
   output logic                  out_vld,
   output logic [LANES*DW-1:0]   out_samp
);

   localparam int VW   = LANES * DW;
   localparam int HALF = LANES / 2;

   generate
      if (LANES != 8) begin : g_bad_lanes
         $error("idct8_row: factorisation is fixed at eight lanes");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("idct8_row: REG_OUT must be 0 or 1");
      end
      if (FRAC < 1 || FRAC >= KW) begin : g_bad_frac
         $error("idct8_row: FRAC must lie in 1..KW-1");
      end
   endgenerate

   logic signed [DW-1:0] xin [LANES];
   logic signed [DW-1:0] dd  [LANES];
   logic signed [DW-1:0] yy  [LANES];
   logic [VW-1:0]        y_vec;

   // Unpack input lanes
   for (genvar i = 0; i < LANES; i++) begin : g_unpack
      assign xin[i] = in_coef[i*DW +: DW];
   end

   idct8_even #(
      .DW(DW), .KW(KW), .FRAC(FRAC),
      .C8(C8), .C16(C16), .C24(C24)
   ) u_even (
      .x0 (xin[0]),
      .x2 (xin[2]),
      .x4 (xin[4]),
      .x6 (xin[6]),
      .d0 (dd[0]),
      .d1 (dd[1]),
      .d2 (dd[2]),
      .d3 (dd[3])
   );

   idct8_odd #(
      .DW(DW), .KW(KW), .FRAC(FRAC),
      .C4(C4), .C12(C12), .C16(C16), .C20(C20), .C28(C28)
   ) u_odd (
      .x1 (xin[1]),
      .x3 (xin[3]),
      .x5 (xin[5]),
      .x7 (xin[7]),
      .d4 (dd[4]),
      .d5 (dd[5]),
      .d6 (dd[6]),
      .d7 (dd[7])
   );

   // Final butterfly: pair lane k with lane 7-k
   for (genvar k = 0; k < HALF; k++) begin : g_final
      assign yy[k]           = dd[k] + dd[LANES-1-k];
      assign yy[LANES-1-k]   = dd[k] - dd[LANES-1-k];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_pack
      assign y_vec[i*DW +: DW] = yy[i];
   end

   generate
      if (REG_OUT == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_vld  <= 1'b0;
               out_samp <= '0;
            end else begin
               out_vld <= in_vld;
               if (in_vld) begin
                  out_samp <= y_vec;
               end
            end
         end

         // Observation helpers for the checks below
         logic signed [DW-1:0] ov [LANES];
         logic in_odd_zero;
         logic in_even_zero;
         logic in_dc_only;
         logic out_flat;
         logic out_mirror;
         logic out_anti;

         for (genvar i = 0; i < LANES; i++) begin : g_ov
            assign ov[i] = out_samp[i*DW +: DW];
         end

         always_comb begin
            in_odd_zero  = 1'b1;
            in_even_zero = 1'b1;
            for (int i = 0; i < LANES; i++) begin
               if (i % 2 == 1 && xin[i] != '0) in_odd_zero  = 1'b0;
               if (i % 2 == 0 && xin[i] != '0) in_even_zero = 1'b0;
            end
            in_dc_only = in_odd_zero;
            for (int i = 1; i < LANES; i++) begin
               if (xin[i] != '0) in_dc_only = 1'b0;
            end
         end

         always_comb begin
            out_flat   = 1'b1;
            out_mirror = 1'b1;
            out_anti   = 1'b1;
            for (int i = 1; i < LANES; i++) begin
               if (ov[i] != ov[0]) out_flat = 1'b0;
            end
            for (int k = 0; k < HALF; k++) begin
               if (ov[k] != ov[LANES-1-k])  out_mirror = 1'b0;
               if (ov[k] != -ov[LANES-1-k]) out_anti   = 1'b0;
            end
         end

         AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> out_vld)
            else $error("out_vld missing one clock after in_vld"); // R7

         AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> (!out_vld && $stable(out_samp)))
            else $error("output changed on an idle cycle"); // R8

         AST_DC_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_dc_only) |=> out_flat)
            else $error("DC-only row did not give equal samples"); // R10

         AST_EVEN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_odd_zero) |=> out_mirror)
            else $error("even-only row lost mirror symmetry"); // R11

         AST_ODD_ANTI: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && in_even_zero) |=> out_anti)
            else $error("odd-only row lost anti-symmetry"); // R12
      end else begin : g_comb
         assign out_vld  = in_vld;
         assign out_samp = y_vec;
      end
   endgenerate

endmodule

// File: tb/sim_idct8_row.sv
module sim_idct8_row;

   localparam int N  = 8;
   localparam int DW = 16;
   localparam int C4 = 16069, C8 = 15137, C12 = 13623, C16 = 11585;
   localparam int C20 = 9102, C24 = 6270, C28 = 3196;
   localparam real PI = 3.14159265358979323846;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_vld = 1'b0;
   logic [N*DW-1:0] in_coef = '0;
   logic           out_vld;
   logic [N*DW-1:0] out_samp;

   int n_chk = 0;
   int n_fail = 0;
   int unsigned seed = 32'h1234_5678;

   always #5 clk = ~clk;

   idct8_row u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .in_coef  (in_coef),
      .out_vld  (out_vld),
      .out_samp (out_samp)
   );

   function automatic int w16(longint v);
      logic signed [15:0] t;
      t = v[15:0];
      return int'(t);
   endfunction

   function automatic int rq(longint v);
      longint s;
      s = (v + 64'sd8192) >>> 14;
      return w16(s);
   endfunction

   function automatic int lane(logic [N*DW-1:0] v, int k);
      logic signed [15:0] t;
      t = v[k*DW +: DW];
      return int'(t);
   endfunction

   function automatic logic [N*DW-1:0] pack(int x[N]);
      logic [N*DW-1:0] v;
      for (int k = 0; k < N; k++) v[k*DW +: DW] = 16'(x[k]);
      return v;
   endfunction

   // Integer model built from R2..R6
   function automatic logic [N*DW-1:0] model(logic [N*DW-1:0] cin);
      longint x[N];
      int d[N];
      int y[N];
      int e0, e1, e2, e3, s4, s5, s6, s7, t0, t1;
      for (int k = 0; k < N; k++) x[k] = longint'(lane(cin, k));
      e0 = rq(x[0]*C16 + x[4]*C16);
      e1 = rq(x[0]*C16 - x[4]*C16);
      e2 = rq(x[2]*C24 - x[6]*C8);
      e3 = rq(x[2]*C8 + x[6]*C24);
      d[0] = w16(e0 + e3);
      d[1] = w16(e1 + e2);
      d[2] = w16(e1 - e2);
      d[3] = w16(e0 - e3);
      s4 = rq(x[1]*C28 - x[7]*C4);
      s7 = rq(x[1]*C4 + x[7]*C28);
      s5 = rq(x[5]*C12 - x[3]*C20);
      s6 = rq(x[5]*C20 + x[3]*C12);
      d[4] = w16(s4 + s5);
      d[7] = w16(s7 + s6);
      t0 = w16(s4 - s5);
      t1 = w16(s7 - s6);
      d[5] = rq(longint'(t1)*C16 - longint'(t0)*C16);
      d[6] = rq(longint'(t1)*C16 + longint'(t0)*C16);
      for (int k = 0; k < N/2; k++) begin
         y[k]     = w16(d[k] + d[N-1-k]);
         y[N-1-k] = w16(d[k] - d[N-1-k]);
      end
      return pack(y);
   endfunction

   function automatic int unsigned next_rand(int unsigned s);
      int unsigned r;
      r = s;
      r = r ^ (r << 13);
      r = r ^ (r >> 17);
      r = r ^ (r << 5);
      return r;
   endfunction

   task automatic check_vec(string req, logic [N*DW-1:0] act, logic [N*DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_int(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge with the
   // result checked. in_vld stays high so calls stream back to back (R7).
   task automatic xform(logic [N*DW-1:0] v, string req);
      in_vld  = 1'b1;
      in_coef = v;
      @(negedge clk);
      check_int({req, " R7 out_vld"}, longint'(out_vld), 1);
      check_vec(req, out_samp, model(v));
   endtask

   function automatic logic [N*DW-1:0] rand_row(int mask_mode, int mag);
      int x[N];
      for (int k = 0; k < N; k++) begin
         seed = next_rand(seed);
         if (mag >= 32768) x[k] = w16(longint'(seed[15:0]));
         else x[k] = int'(seed % (2*mag + 1)) - mag;
         if (mask_mode == 1 && (k % 2 == 1)) x[k] = 0;
         if (mask_mode == 2 && (k % 2 == 0)) x[k] = 0;
      end
      return pack(x);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int amps[7] = '{1, -1, 64, -64, 1000, 32767, -32768};
      int x[N];
      logic [N*DW-1:0] v;
      logic [N*DW-1:0] held;

      // R9: reset state
      repeat (3) @(negedge clk);
      check_int("R9 out_vld in reset", longint'(out_vld), 0);
      check_vec("R9 out_samp in reset", out_samp, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_int("R9 out_vld after reset", longint'(out_vld), 0);

      // R1 R10: DC of 16384 gives 11585 in every lane
      for (int k = 0; k < N; k++) x[k] = 0;
      x[0] = 16384;
      xform(pack(x), "R1 R10 dc");
      for (int k = 0; k < N; k++) check_int("R1 R10 dc lane", lane(out_samp, k), 11585);

      // Impulses on every lane (R1, R3 for even lanes, R4 R5 for odd lanes)
      for (int ln = 0; ln < N; ln++) begin
         for (int a = 0; a < 7; a++) begin
            for (int k = 0; k < N; k++) x[k] = 0;
            x[ln] = amps[a];
            xform(pack(x), (ln % 2 == 0) ? "R1 R3 R6 impulse" : "R1 R4 R5 R6 impulse");
         end
      end

      // DC sweep (R2 rounding, R10 flatness)
      for (int dc = -2048; dc < 2048; dc++) begin
         for (int k = 0; k < N; k++) x[k] = 0;
         x[0] = dc;
         xform(pack(x), "R2 R10 dc sweep");
         check_int("R10 dc flat", lane(out_samp, 7), rq(longint'(dc) * C16));
      end

      // Full-range rows: rounding and wrap (R2, R6)
      for (int i = 0; i < 1500; i++) xform(rand_row(0, 32768), "R2 R6 random");

      // Even-only rows: mirror symmetry (R11)
      for (int i = 0; i < 400; i++) begin
         xform(rand_row(1, 32768), "R3 R11 even-only");
         for (int k = 0; k < N/2; k++)
            check_int("R11 mirror", lane(out_samp, k), lane(out_samp, N-1-k));
      end

      // Odd-only rows: anti-symmetry (R12)
      for (int i = 0; i < 400; i++) begin
         xform(rand_row(2, 32768), "R5 R12 odd-only");
         for (int k = 0; k < N/2; k++)
            check_int("R12 anti", lane(out_samp, k), w16(-lane(out_samp, N-1-k)));
      end

      // Accuracy against the real-valued transform (R13)
      for (int i = 0; i < 800; i++) begin
         v = rand_row(0, 512);
         xform(v, "R13 small");
         for (int n = 0; n < N; n++) begin
            real r;
            real err;
            r = real'(lane(v, 0)) * $cos(PI / 4.0);
            for (int k = 1; k < N; k++)
               r = r + real'(lane(v, k)) * $cos(real'((2*n + 1) * k) * PI / 16.0);
            err = real'(lane(out_samp, n)) - r;
            n_chk++;
            if (err > 3.0 || err < -3.0) begin
               n_fail++;
               $display("FAIL R13 lane %0d act=%0d exp=%f", n, lane(out_samp, n), r);
            end
         end
      end

      // Idle cycles with changing input (R8), then resume (R7)
      held = out_samp;
      in_vld = 1'b0;
      for (int i = 0; i < 4; i++) begin
         in_coef = rand_row(0, 32768);
         @(negedge clk);
         check_int("R8 idle out_vld", longint'(out_vld), 0);
         check_vec("R8 idle hold", out_samp, held);
      end
      xform(rand_row(0, 32768), "R7 resume");
      in_vld = 1'b0;
      @(negedge clk);
      check_int("R7 out_vld drops", longint'(out_vld), 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule